// File: doc/BRIEF.md
# Multi-Input Edge Wakeup Controller

This block sits beside a halted controller and watches an input port of `PINS` lines (eight by default). Every line has three per-pin control bits held in three software-visible registers: an arm bit that lets the line wake the controller, a polarity bit that picks which transition counts, and a sticky latch that records that the chosen transition has happened. Software reads and writes all three through a small synchronous bus. Writes take effect on the clock edge. Reads return data combinationally.

Transition detection runs on every clock, whatever the arm bits hold, so a disarmed line still records its edges. When an armed line has its latch set, the block raises a single-cycle wake pulse. While that condition lasts, it also refuses any request to halt. Only software clears a latch. If a clear and a new edge land in the same cycle, the edge wins.

Input synchronisation and oscillator restart are handled outside the block. The port arrives here as clean synchronous levels.

Top module: `mwu_wakeup_ctrl`

## Requirements
- R1: After reset, the arm register (address 2'b00) and the polarity register (address 2'b01) both read 0, and `wake_o` is 0. The latch register has no defined reset value.
- R2: A write stores `bus_wdata_i` into the register chosen by `bus_addr_i`: 2'b00 is arm, 2'b01 is polarity, 2'b10 is latch. Reading the same address then returns the stored value. Address 2'b11 reads as 0.
- R3: When a line's polarity bit is 0, a low-to-high transition on that line sets its latch bit, and a high-to-low transition leaves it unchanged. The latch bit is readable in the cycle after the edge is sampled.
- R4: When a line's polarity bit is 1, a high-to-low transition sets its latch bit, and a low-to-high transition leaves it unchanged.
- R5: Edges are latched even when the line's arm bit is 0. Such a latch does not cause a wake pulse and does not block a halt.
- R6: A latch bit stays set until software writes 0 to it at address 2'b10. A software write of 1 sets the bit.
- R7: If a selected edge and a software clear of the same latch bit occur in the same cycle, the bit ends up set.
- R8: `halt_ok_o` is combinationally `halt_req_i` AND NOT (any bit both armed and latched).
- R9: `wake_o` is a registered pulse, high for exactly one cycle. It goes high on the clock after the armed-and-latched condition first becomes true. It does not repeat while that condition stays true.
- R10: Writing the polarity register while the lines are stable sets no latch bit. The sequence disarm, change polarity, clear latch, re-arm therefore produces no wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register select for read and write |
| bus_wdata_i | input | PINS | Write data |
| bus_rdata_o | output | PINS | Read data for `bus_addr_i`, combinational |
| pin_i | input | PINS | Synchronous port levels |
| halt_req_i | input | 1 | Request to enter halt |
| halt_ok_o | output | 1 | Halt request granted |
| wake_o | output | 1 | One-cycle wakeup pulse |

## Verification
If a line changes in cycle c, the block samples it at the next edge, so the latch bit reads back in cycle c+1 and `halt_ok_o` drops in that same cycle. The wake pulse is due in cycle c+2 only, and `wake_o` must be low again from c+3. Register writes read back in the cycle after the write strobe. The halt grant is compared in the same cycle as the request. The driver queues each expectation with the cycle number in which it is due, including low values in the cycles around the pulse. The monitor compares on the falling edge and only in that cycle, so neither an early result nor a late one escapes notice.

// File: rtl/mwu_pkg.sv
package mwu_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_ARM   = 2'd0,
        REG_POL   = 2'd1,
        REG_LATCH = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/mwu_edge_detect.sv
module mwu_edge_detect #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_i,
    input  logic [PINS-1:0] fall_sel_i,
    output logic [PINS-1:0] hit_o
);

    typedef struct packed {
        logic [PINS-1:0] prev;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // one comparator per line; polarity picks which transition is a hit
    for (genvar g = 0; g < PINS; g++) begin : g_line
        always_comb begin
            if (fall_sel_i[g]) hit_o[g] = st_q.prev[g] & ~pin_i[g];
            else               hit_o[g] = ~st_q.prev[g] & pin_i[g];
        end
    end

endmodule

// File: rtl/mwu_regs.sv
module mwu_regs #(
    parameter int PINS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  mwu_pkg::reg_sel_e  sel_i,
    input  logic [PINS-1:0]    wdata_i,
    input  logic [PINS-1:0]    hit_i,
    output logic [PINS-1:0]    arm_o,
    output logic [PINS-1:0]    pol_o,
    output logic [PINS-1:0]    latch_o
);
    import mwu_pkg::*;

    typedef struct packed {
        logic [PINS-1:0] arm;
        logic [PINS-1:0] pol;
        logic [PINS-1:0] latch;
    } state_t;

    state_t          st_d, st_q;
    logic [PINS-1:0] latch_base;

    always_comb begin
        st_d = st_q;
        if (wr_i && sel_i == REG_ARM) st_d.arm = wdata_i;
        if (wr_i && sel_i == REG_POL) st_d.pol = wdata_i;
        latch_base = (wr_i && sel_i == REG_LATCH) ? wdata_i : st_q.latch;
        // a detected edge overrides a simultaneous software clear
        st_d.latch = latch_base | hit_i;
    end

    // latch reset to zero is for simulation tidiness only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign arm_o   = st_q.arm;
    assign pol_o   = st_q.pol;
    assign latch_o = st_q.latch;

endmodule

// File: rtl/mwu_wake.sv
module mwu_wake #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] arm_i,
    input  logic [PINS-1:0] latch_i,
    input  logic            halt_req_i,
    output logic            halt_ok_o,
    output logic            wake_o
);

    typedef struct packed {
        logic cond;
        logic wake;
    } state_t;

    state_t st_d, st_q;
    logic   cond;

    assign cond = |(arm_i & latch_i);

    always_comb begin
        st_d      = st_q;
        st_d.cond = cond;
        st_d.wake = cond & ~st_q.cond;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign halt_ok_o = halt_req_i & ~cond;
    assign wake_o    = st_q.wake;

endmodule

// File: rtl/mwu_wakeup_ctrl.sv
module mwu_wakeup_ctrl #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr_i,
    input  logic [1:0]      bus_addr_i,
    input  logic [PINS-1:0] bus_wdata_i,
    output logic [PINS-1:0] bus_rdata_o,
    input  logic [PINS-1:0] pin_i,
    input  logic            halt_req_i,
    output logic            halt_ok_o,
    output logic            wake_o
);
    import mwu_pkg::*;

    reg_sel_e        sel;
    logic [PINS-1:0] hit_w;
    logic [PINS-1:0] arm_w;
    logic [PINS-1:0] pol_w;
    logic [PINS-1:0] latch_w;

    assign sel = reg_sel_e'(bus_addr_i);

    mwu_edge_detect #(.PINS(PINS)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .fall_sel_i (pol_w),
        .hit_o      (hit_w)
    );

    mwu_regs #(.PINS(PINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr_i),
        .sel_i   (sel),
        .wdata_i (bus_wdata_i),
        .hit_i   (hit_w),
        .arm_o   (arm_w),
        .pol_o   (pol_w),
        .latch_o (latch_w)
    );

    mwu_wake #(.PINS(PINS)) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (arm_w),
        .latch_i    (latch_w),
        .halt_req_i (halt_req_i),
        .halt_ok_o  (halt_ok_o),
        .wake_o     (wake_o)
    );

    always_comb begin
        case (sel)
            REG_ARM:   bus_rdata_o = arm_w;
            REG_POL:   bus_rdata_o = pol_w;
            REG_LATCH: bus_rdata_o = latch_w;
            default:   bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/mwu_wakeup_ctrl_chk.sv
module mwu_wakeup_ctrl_chk #(
    parameter int PINS = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr,
    input logic [1:0]      addr,
    input logic [PINS-1:0] arm,
    input logic [PINS-1:0] latch,
    input logic [PINS-1:0] hit,
    input logic            halt_req,
    input logic            halt_ok,
    input logic            wake
);

    p_wake_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

    p_wake_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake) |-> $past(|(arm & latch)));

    p_halt_veto_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(arm & latch)) |-> !halt_ok);

    p_halt_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !(|(arm & latch))) |-> halt_ok);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((latch & $past(hit)) == $past(hit)));

    p_latch_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == 2'd2) |=> ((latch & $past(latch)) == $past(latch)));

endmodule

bind mwu_wakeup_ctrl mwu_wakeup_ctrl_chk #(.PINS(PINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_wr_i),
    .addr     (bus_addr_i),
    .arm      (arm_w),
    .latch    (latch_w),
    .hit      (hit_w),
    .halt_req (halt_req_i),
    .halt_ok  (halt_ok_o),
    .wake     (wake_o)
);

// File: tb/tb_mwu_wakeup_ctrl.sv
`timescale 1ns/1ps
module tb_mwu_wakeup_ctrl;

    localparam logic [1:0] A_ARM = 2'd0, A_POL = 2'd1, A_LAT = 2'd2, A_NONE = 2'd3;
    localparam int SEL_RD = 0, SEL_WAKE = 1, SEL_HALT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [7:0] pins = 8'd0;
    logic       halt_req = 1'b0;
    logic       halt_ok;
    logic       wake;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int         due;
        int         sel;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t sb[$];

    mwu_wakeup_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .pin_i       (pins),
        .halt_req_i  (halt_req),
        .halt_ok_o   (halt_ok),
        .wake_o      (wake)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares every queued item in exactly its due cycle
    always @(negedge clk) begin
        item_t keep[$];
        logic [7:0] act;
        keep = {};
        foreach (sb[i]) begin
            if (sb[i].due == cyc) begin
                case (sb[i].sel)
                    SEL_RD:   act = bus_rdata;
                    SEL_WAKE: act = {7'd0, wake};
                    default:  act = {7'd0, halt_ok};
                endcase
                checks++;
                if (act !== sb[i].exp) begin
                    errors++;
                    $display("FAIL %s cycle %0d sel %0d actual %h expected %h",
                             sb[i].req, cyc, sb[i].sel, act, sb[i].exp);
                end
            end else begin
                keep.push_back(sb[i]);
            end
        end
        sb = keep;
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input int due, input int sel, input logic [7:0] e, input string r);
        item_t it;
        it.due = due; it.sel = sel; it.exp = e; it.req = r;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string r);
        bus_addr = a;
        push(cyc, SEL_RD, e, r);
        step();
    endtask

    task automatic chk_halt(input logic e, input string r);
        push(cyc, SEL_HALT, {7'd0, e}, r);
        step();
    endtask

    task automatic drive(input logic [7:0] v);
        pins = v;
        step();
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired, actual hung expected finished");
            report();
        end
    end

    initial begin
        int c;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        push(cyc, SEL_WAKE, 8'h00, "R1");
        rd(A_ARM, 8'h00, "R1");
        rd(A_POL, 8'h00, "R1");

        // R2 register write and read back
        wr(A_ARM, 8'hFF);
        rd(A_ARM, 8'hFF, "R2");
        wr(A_POL, 8'h0F);
        rd(A_POL, 8'h0F, "R2");
        rd(A_NONE, 8'h00, "R2");
        wr(A_POL, 8'h00);
        wr(A_LAT, 8'h00);
        rd(A_LAT, 8'h00, "R6");
        halt_req = 1'b1;
        chk_halt(1'b1, "R8");

        // R3 rising edge on line 0, R9 pulse timing
        c = cyc;
        push(c,     SEL_WAKE, 8'h00, "R9");
        push(c + 1, SEL_WAKE, 8'h00, "R9");
        push(c + 1, SEL_HALT, 8'h00, "R8");
        push(c + 2, SEL_WAKE, 8'h01, "R9");
        push(c + 3, SEL_WAKE, 8'h00, "R9");
        push(c + 4, SEL_WAKE, 8'h00, "R9");
        push(c + 5, SEL_WAKE, 8'h00, "R9");
        drive(8'h01);
        rd(A_LAT, 8'h01, "R3");
        drive(8'h00);
        rd(A_LAT, 8'h01, "R3");
        step();
        wr(A_LAT, 8'h00);
        chk_halt(1'b1, "R8");
        halt_req = 1'b0;
        chk_halt(1'b0, "R8");

        // R4 falling-edge polarity on line 1
        wr(A_POL, 8'h02);
        drive(8'h02);
        rd(A_LAT, 8'h00, "R4");
        drive(8'h00);
        rd(A_LAT, 8'h02, "R4");
        wr(A_LAT, 8'h00);

        // R5 disarmed line still latches, no wake, no veto
        wr(A_ARM, 8'hFE);
        c = cyc;
        push(c + 1, SEL_WAKE, 8'h00, "R5");
        push(c + 2, SEL_WAKE, 8'h00, "R5");
        push(c + 3, SEL_WAKE, 8'h00, "R5");
        drive(8'h01);
        rd(A_LAT, 8'h01, "R5");
        halt_req = 1'b1;
        chk_halt(1'b1, "R5");
        drive(8'h00);
        wr(A_LAT, 8'h00);

        // R6 sticky latch, software set and clear
        drive(8'h10);
        step(); step(); step();
        rd(A_LAT, 8'h10, "R6");
        wr(A_LAT, 8'h90);
        rd(A_LAT, 8'h90, "R6");
        wr(A_LAT, 8'h00);
        rd(A_LAT, 8'h00, "R6");

        // R7 edge and clear in the same cycle
        pins = 8'h14;
        wr(A_LAT, 8'h00);
        rd(A_LAT, 8'h04, "R7");
        wr(A_LAT, 8'h00);

        // R10 polarity change with stable lines, safe re-arm sequence
        wr(A_POL, 8'h06);
        rd(A_LAT, 8'h00, "R10");
        wr(A_ARM, 8'hF6);
        wr(A_POL, 8'h0E);
        wr(A_LAT, 8'h00);
        c = cyc;
        push(c,     SEL_WAKE, 8'h00, "R10");
        push(c + 1, SEL_WAKE, 8'h00, "R10");
        push(c + 2, SEL_WAKE, 8'h00, "R10");
        wr(A_ARM, 8'hFE);
        rd(A_LAT, 8'h00, "R10");
        step();
        drive(8'h1C);
        rd(A_LAT, 8'h00, "R4");
        drive(8'h14);
        rd(A_LAT, 8'h08, "R10");

        step(); step();
        done = 1'b1;
        report();
    end

endmodule